// File: doc/BRIEF.md
# Impact-Ordered Cache Configuration Tuner

This block searches the configuration space of a configurable two-level cache hierarchy for a low-energy setting without trying every combination. It tunes one configuration field at a time and holds every other field at the best value found so far. For each candidate it presents the configuration to the cache, lets the workload run for a programmable number of cycles, and then asks an external estimator for an energy figure. The instruction-side hierarchy is tuned completely before the data-side hierarchy.

The fields are swept in order of how strongly they affect energy: capacity first, then line length, then associativity. For each of these the first-level field is swept before the second-level field. Each sweep starts at the smallest value and moves upward. A sweep ends early once a candidate costs more energy than the best seen in that sweep. Combinations the cache cannot build, where associativity exceeds capacity on a level, are skipped without being evaluated. When both sides are finished the tuner raises a done flag. It keeps the two chosen configurations on its outputs until the next start.

Top module: `cache_tuner`

## Requirements
- R1: After reset, `done_o`, `trial_o` and `energy_req_o` are 0.
- R2: A configuration word has six 2-bit index fields. Bits [1:0] hold the L1 size, [3:2] the L2 size, [5:4] the L1 line, [7:6] the L2 line, [9:8] the L1 associativity and [11:10] the L2 associativity. The fields are swept in that order, lowest field first, for side 0 (instruction, `cand_side_o`=0) and then for side 1 (data). Side 1 never goes back to side 0 without a start.
- R3: Each tuning run begins from the word 12'h888 on both sides: every L1 field at index 0, and L2 size, line and associativity at index 2 (64 KB, 64-byte lines, 4-way). While a field is swept, every other field holds its best value so far. `icfg_o` and `dcfg_o` show 12'h888 after reset.
- R4: A candidate whose associativity index exceeds its size index on the same level is never put on trial.
- R5: `energy_req_o` rises exactly `window_i`+1 cycles after `trial_o` rises. `cand_cfg_o` and `cand_side_o` stay constant while `trial_o` is high.
- R6: The first legal candidate of a sweep sets the best energy. A strictly lower energy replaces both the best energy and the chosen value. An equal energy keeps the earlier, smaller value and the sweep continues.
- R7: A candidate whose energy is strictly above the sweep's best energy ends that sweep at once, and the next field starts.
- R8: A sweep whose energy never rises goes through every index up to the field's maximum (3 by default), skipping only the illegal ones.
- R9: After the last data-side field, `done_o` is 1 and `icfg_o`/`dcfg_o` hold the chosen words. They stay unchanged until `start_i` is pulsed.
- R10: `start_i` has no effect while a run is in progress: the candidate sequence and the final words are the same as without the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a tuning run when idle or done |
| window_i | input | 16 | Evaluation window length in cycles, minus one |
| energy_i | input | 32 | Unsigned energy of the current candidate |
| energy_vld_i | input | 1 | One-cycle strobe qualifying `energy_i` |
| trial_o | output | 1 | A candidate is applied and under evaluation |
| cand_side_o | output | 1 | Side being tuned: 0 instruction, 1 data |
| cand_cfg_o | output | 12 | Configuration word presented to the cache |
| energy_req_o | output | 1 | Window elapsed; waiting for an energy value |
| done_o | output | 1 | Tuning finished; chosen words valid |
| icfg_o | output | 12 | Best instruction-side configuration word |
| dcfg_o | output | 12 | Best data-side configuration word |

## Verification
The assertions assume that `window_i` stays constant for a whole run and that `energy_vld_i` pulses for a single cycle, and only while `energy_req_o` is high. The stimulus meets both assumptions. The bench's estimator model answers only a raised request, with a random latency of zero to three cycles, and drops the strobe after one cycle. The window length is changed only between runs, while the tuner reports done. Energy values come from per-field weight tables: random, rising, falling and flat. This makes the sweeps stop early, run to the end and resolve ties under the same assumptions.

// File: rtl/tuner_pkg.sv
package tuner_pkg;

    localparam int NUM_FIELDS = 6;
    localparam int NUM_LEVELS = 2;
    // field index = level + NUM_LEVELS * parameter rank (size, line, assoc)
    localparam int F_SIZE0  = 0;
    localparam int F_ASSOC0 = 2 * NUM_LEVELS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_EVAL,
        ST_MEAS,
        ST_DONE
    } tune_state_e;

endpackage

// File: rtl/tuner_timer.sv
module tuner_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    output logic          zero_o
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tuner_cfg_compose.sv
module tuner_cfg_compose
    import tuner_pkg::*;
#(
    parameter int FW = 2,
    parameter int SW = 3,
    localparam int CFGW = NUM_FIELDS * FW
) (
    input  logic [CFGW-1:0] base_i,
    input  logic [SW-1:0]   sel_i,
    input  logic [FW-1:0]   val_i,
    output logic [CFGW-1:0] cfg_o,
    output logic            legal_o
);

    logic [NUM_LEVELS-1:0] lvl_ok;

    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
        assign cfg_o[f*FW +: FW] = (sel_i == SW'(f)) ? val_i : base_i[f*FW +: FW];
    end

    for (genvar lv = 0; lv < NUM_LEVELS; lv++) begin : g_level
        assign lvl_ok[lv] = cfg_o[(F_ASSOC0+lv)*FW +: FW] <= cfg_o[(F_SIZE0+lv)*FW +: FW];
    end

    assign legal_o = &lvl_ok;

endmodule

// File: rtl/cache_tuner.sv
module cache_tuner
    import tuner_pkg::*;
#(
    parameter int FW            = 2,
    parameter int CW            = 16,
    parameter int EW            = 32,
    parameter int MAX_SIZE      = 3,
    parameter int MAX_LINE      = 3,
    parameter int MAX_ASSOC     = 3,
    parameter int L2_INIT_SIZE  = 2,
    parameter int L2_INIT_LINE  = 2,
    parameter int L2_INIT_ASSOC = 2,
    localparam int CFGW = NUM_FIELDS * FW,
    localparam int SW   = $clog2(NUM_FIELDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CW-1:0]   window_i,
    input  logic [EW-1:0]   energy_i,
    input  logic            energy_vld_i,
    output logic            trial_o,
    output logic            cand_side_o,
    output logic [CFGW-1:0] cand_cfg_o,
    output logic            energy_req_o,
    output logic            done_o,
    output logic [CFGW-1:0] icfg_o,
    output logic [CFGW-1:0] dcfg_o
);

    localparam logic [CFGW-1:0] INIT_CFG = {FW'(L2_INIT_ASSOC), FW'(0),
                                            FW'(L2_INIT_LINE),  FW'(0),
                                            FW'(L2_INIT_SIZE),  FW'(0)};

    typedef struct packed {
        tune_state_e                st;
        logic                       side;
        logic [SW-1:0]              step;
        logic [FW-1:0]              cand;
        logic                       first;
        logic [EW-1:0]              best;
        logic [1:0][CFGW-1:0]       held;
    } ctx_t;

    ctx_t            q, d;
    logic            tmr_load, tmr_zero, cand_legal, adv;
    logic [FW-1:0]   fmax;
    logic [CFGW-1:0] base_cfg, cand_cfg;

    function automatic logic [FW-1:0] field_max(input logic [SW-1:0] step);
        case (step)
            SW'(0), SW'(1): field_max = FW'(MAX_SIZE);
            SW'(2), SW'(3): field_max = FW'(MAX_LINE);
            default:        field_max = FW'(MAX_ASSOC);
        endcase
    endfunction

    assign base_cfg = q.held[q.side];

    tuner_cfg_compose #(.FW(FW), .SW(SW)) u_compose (
        .base_i  (base_cfg),
        .sel_i   (q.step),
        .val_i   (q.cand),
        .cfg_o   (cand_cfg),
        .legal_o (cand_legal)
    );

    tuner_timer #(.CW(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (window_i),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        d        = q;
        tmr_load = 1'b0;
        adv      = 1'b0;
        fmax     = field_max(q.step);
        case (q.st)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    d.st    = ST_PICK;
                    d.side  = 1'b0;
                    d.step  = '0;
                    d.cand  = '0;
                    d.first = 1'b1;
                    d.held  = {INIT_CFG, INIT_CFG};
                end
            end
            ST_PICK: begin
                if (cand_legal) begin
                    tmr_load = 1'b1;
                    d.st     = ST_EVAL;
                end else if (q.cand == fmax) begin
                    adv = 1'b1;
                end else begin
                    d.cand = q.cand + 1'b1;
                end
            end
            ST_EVAL: begin
                if (tmr_zero) d.st = ST_MEAS;
            end
            ST_MEAS: begin
                if (energy_vld_i) begin
                    if (q.first || energy_i < q.best) begin
                        d.best          = energy_i;
                        d.first         = 1'b0;
                        d.held[q.side]  = cand_cfg;
                    end
                    if (!q.first && energy_i > q.best) begin
                        adv = 1'b1;
                    end else if (q.cand == fmax) begin
                        adv = 1'b1;
                    end else begin
                        d.cand = q.cand + 1'b1;
                        d.st   = ST_PICK;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (adv) begin
            d.cand  = '0;
            d.first = 1'b1;
            d.st    = ST_PICK;
            if (q.step == SW'(NUM_FIELDS - 1)) begin
                d.step = '0;
                if (q.side) d.st = ST_DONE;
                else        d.side = 1'b1;
            end else begin
                d.step = q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.first <= 1'b1;
            q.held  <= {INIT_CFG, INIT_CFG};
        end else begin
            q <= d;
        end
    end

    assign trial_o      = (q.st == ST_EVAL) || (q.st == ST_MEAS);
    assign energy_req_o = (q.st == ST_MEAS);
    assign done_o       = (q.st == ST_DONE);
    assign cand_side_o  = q.side;
    assign cand_cfg_o   = cand_cfg;
    assign icfg_o       = q.held[0];
    assign dcfg_o       = q.held[1];

endmodule

// File: rtl/cache_tuner_chk.sv
module cache_tuner_chk #(
    parameter int FW = 2,
    parameter int CW = 16,
    localparam int CFGW = 6 * FW
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start_i,
    input logic [CW-1:0]   window_i,
    input logic            trial_o,
    input logic            cand_side_o,
    input logic [CFGW-1:0] cand_cfg_o,
    input logic            energy_req_o,
    input logic            done_o,
    input logic [CFGW-1:0] icfg_o,
    input logic [CFGW-1:0] dcfg_o
);

    logic [CW:0] win_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        win_cnt_q <= '0;
        else if (!trial_o)                 win_cnt_q <= '0;
        else if (!energy_req_o)            win_cnt_q <= win_cnt_q + 1'b1;
    end

    // R4: only buildable combinations go on trial
    a_r4_legal_only: assert property (@(posedge clk) disable iff (!rst_n)
        trial_o |-> (cand_cfg_o[4*FW +: FW] <= cand_cfg_o[0 +: FW]) &&
                    (cand_cfg_o[5*FW +: FW] <= cand_cfg_o[1*FW +: FW]));

    // R5: energy request follows the window length
    a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(energy_req_o) |-> (win_cnt_q == {1'b0, window_i} + 1'b1));

    // R5: candidate stays put during its trial
    a_r5_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        trial_o |=> (!trial_o || ($stable(cand_cfg_o) && $stable(cand_side_o))));

    // R2: data side never falls back to instruction side mid-run
    a_r2_side_order: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cand_side_o) |-> $past(start_i));

    // R9: result held until a new start
    a_r9_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(icfg_o) && $stable(dcfg_o)));

    // R9: no trial while done
    a_r9_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!trial_o && !energy_req_o));

endmodule

bind cache_tuner cache_tuner_chk #(.FW(FW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .window_i     (window_i),
    .trial_o      (trial_o),
    .cand_side_o  (cand_side_o),
    .cand_cfg_o   (cand_cfg_o),
    .energy_req_o (energy_req_o),
    .done_o       (done_o),
    .icfg_o       (icfg_o),
    .dcfg_o       (dcfg_o)
);

// File: tb/cache_tuner_tb.sv
`timescale 1ns/1ps
module cache_tuner_tb;

    logic        clk = 1'b0;
    logic        rst_n, start_i, energy_vld_i;
    logic [15:0] window_i;
    logic [31:0] energy_i;
    logic        trial_o, cand_side_o, energy_req_o, done_o;
    logic [11:0] cand_cfg_o, icfg_o, dcfg_o;

    always #2 clk = ~clk;

    cache_tuner u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .window_i(window_i),
        .energy_i(energy_i), .energy_vld_i(energy_vld_i), .trial_o(trial_o),
        .cand_side_o(cand_side_o), .cand_cfg_o(cand_cfg_o),
        .energy_req_o(energy_req_o), .done_o(done_o),
        .icfg_o(icfg_o), .dcfg_o(dcfg_o)
    );

    int total = 0;
    int bad   = 0;
    int unsigned w [2][6][4];
    logic        exp_side [64];
    logic [11:0] exp_cfg  [64];
    logic [11:0] exp_fin  [2];
    int exp_n   = 0;
    int obs_idx = 0;
    int cur_w   = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic bit legal(input logic [11:0] c);
        return (c[9:8] <= c[1:0]) && (c[11:10] <= c[3:2]);
    endfunction

    function automatic logic [31:0] energy_of(input logic s, input logic [11:0] c);
        logic [31:0] e = 32'd100;
        for (int f = 0; f < 6; f++) e += w[s][f][c[f*2 +: 2]];
        return e;
    endfunction

    task automatic set_weights(input int mode);
        for (int s = 0; s < 2; s++)
            for (int f = 0; f < 6; f++)
                for (int v = 0; v < 4; v++)
                    case (mode)
                        1:       w[s][f][v] = v * 100 + f;
                        2:       w[s][f][v] = (3 - v) * 100;
                        3:       w[s][f][v] = 50;
                        default: w[s][f][v] = $urandom_range(0, 999);
                    endcase
    endtask

    task automatic ref_run();
        exp_n = 0;
        for (int s = 0; s < 2; s++) begin
            logic [11:0] held = 12'h888;
            for (int f = 0; f < 6; f++) begin
                bit          first = 1'b1;
                logic [31:0] best  = '0;
                logic [1:0]  hv    = held[f*2 +: 2];
                for (int v = 0; v < 4; v++) begin
                    logic [11:0] c = held;
                    logic [31:0] e;
                    c[f*2 +: 2] = 2'(v);
                    if (!legal(c)) continue;
                    exp_side[exp_n] = 1'(s);
                    exp_cfg[exp_n]  = c;
                    exp_n++;
                    e = energy_of(1'(s), c);
                    if (first || e < best) begin
                        best = e; hv = 2'(v); first = 1'b0;
                    end else if (e > best) begin
                        break;
                    end
                end
                held[f*2 +: 2] = hv;
            end
            exp_fin[s] = held;
        end
    endtask

    // estimator model and trial monitor
    initial begin
        int lat  = 0;
        int wcnt = 0;
        energy_vld_i = 1'b0;
        energy_i     = '0;
        forever begin
            @(negedge clk);
            if (trial_o && !energy_req_o) wcnt++;
            else if (!trial_o) wcnt = 0;
            if (energy_req_o && wcnt != 0) begin
                chk("R5 window", 64'(wcnt), 64'(cur_w + 1));
                wcnt = 0;
            end
            if (energy_vld_i) begin
                energy_vld_i = 1'b0;
            end else if (energy_req_o) begin
                if (lat == 0) begin
                    if (obs_idx < exp_n)
                        chk("R2_R3 candidate", {cand_side_o, cand_cfg_o},
                            {exp_side[obs_idx], exp_cfg[obs_idx]});
                    else
                        chk("R7 extra trial", 64'(obs_idx), 64'(exp_n - 1));
                    chk("R4 legal", 64'(legal(cand_cfg_o)), 64'd1);
                    obs_idx++;
                    energy_i     = energy_of(cand_side_o, cand_cfg_o);
                    energy_vld_i = 1'b1;
                    lat          = $urandom_range(0, 3);
                end else begin
                    lat--;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic run(input int mode, input int win, input bit mid_start, input string tag);
        logic [11:0] ic, dc;
        set_weights(mode);
        ref_run();
        window_i = 16'(win);
        cur_w    = win;
        obs_idx  = 0;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (mid_start) begin
            repeat (30) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        chk({tag, " trial count"}, 64'(obs_idx), 64'(exp_n));
        chk("R6 icfg", 64'(icfg_o), 64'(exp_fin[0]));
        chk("R6 dcfg", 64'(dcfg_o), 64'(exp_fin[1]));
        ic = icfg_o;
        dc = dcfg_o;
        repeat (20) @(negedge clk);
        chk("R9 done held", 64'(done_o), 64'd1);
        chk("R9 cfg held", {ic, dc}, {icfg_o, dcfg_o});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        start_i  = 1'b0;
        window_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done", 64'(done_o), 64'd0);
        chk("R1 trial", 64'(trial_o), 64'd0);
        chk("R1 req", 64'(energy_req_o), 64'd0);
        chk("R3 reset cfg", {icfg_o, dcfg_o}, {12'h888, 12'h888});
        repeat (5) @(negedge clk);
        chk("R1 idle", 64'(trial_o), 64'd0);

        run(1, 0, 1'b0, "R7 rising");
        run(2, 5, 1'b0, "R8 falling");
        run(3, 1, 1'b0, "R6 flat");
        run(0, 3, 1'b0, "R8 random");
        run(0, 2, 1'b1, "R10 restart");
        for (int i = 0; i < 4; i++) run(0, int'($urandom_range(0, 7)), 1'b0, "R7 random");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule